// File: doc/BRIEF.md
# HDLC receive frame error detector

This block watches one serial HDLC receive line, qualified by a bit-valid strobe, and judges every frame it sees. It finds the opening and closing flags and drops the zero a transmitter inserts after five ones. It counts the destuffed bits between flags and runs the frame check sequence over them, using either the 16-bit or the 32-bit CRC as chosen by a select input. Each closed frame is given one of four classes: good, FCS error, abort, or format error.

The three error classes each have a sticky status bit and an interrupt enable. A status bit records its event whether or not its enable is set, so software can poll with interrupts masked. A status bit is cleared by pulsing the matching bit of a write-one-to-clear input. A single level interrupt output combines the enabled status bits. A one-cycle frame-done pulse with the class code reports each verdict as it happens.

Top module: `hdlc_rx_err_det`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `stat`, `irq` and `frm_done` are all zero.
- R2: A flag is a zero, six ones and a zero on the line. A zero that follows five ones inside a frame is removed before length counting and CRC, so payload bytes of 0xFF pass as good frames. Flags with nothing between them report no frame.
- R3: With `crc32_sel`=0 the CRC is polynomial 0x1021, preset all ones, good residue 0x1D0F. With `crc32_sel`=1 it is 0x04C11DB7, preset all ones, good residue 0xC704DD7B. Bits enter in line order, each byte least significant bit first. A residue mismatch gives class 1 and sets `stat[0]`.
- R4: Seven consecutive ones while a frame is open, with more than five destuffed bits since its flag, give class 2 and set `stat[1]`. The receiver then ignores the line until the next flag. Ones following a flag with no data in between are not an abort.
- R5: The frame length L counts the destuffed bits between flags, FCS included. L below 32 with `crc32_sel`=0, or below 48 with `crc32_sel`=1, gives class 3 and sets `stat[2]`. L equal to the minimum is legal.
- R6: L greater than 8 times `max_octets` gives class 3 and sets `stat[2]`. L equal to that limit is legal.
- R7: L that is not a multiple of 8 gives class 3 and sets `stat[2]`.
- R8: A frame with a format error reports class 3 only, even if its FCS is also wrong. An aborted frame reports only the abort.
- R9: `frm_done` pulses for one cycle, on the clock edge that samples the closing flag's last bit or the seventh one of an abort, with `frm_class` (0 good, 1 FCS, 2 abort, 3 format). A good frame sets no status bit.
- R10: Status bits stay set until a one is written to the same bit of `stat_clr`; a one in any other bit leaves them set. When an event and its clear coincide, the bit stays set.
- R11: `irq` is high one cycle after any bit of `stat` and `int_en` are both high. Status bits set even when their enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received line bit |
| rx_vld | input | 1 | rx_bit is valid this cycle |
| crc32_sel | input | 1 | 0: 16-bit CRC, 1: 32-bit CRC |
| max_octets | input | LEN_W | Largest legal frame length in octets, FCS included |
| int_en | input | 3 | Interrupt enable per class: [0] FCS, [1] abort, [2] format |
| stat_clr | input | 3 | Write-one-to-clear pulses for the status bits |
| stat | output | 3 | Sticky status: [0] FCS, [1] abort, [2] format |
| irq | output | 1 | Level interrupt |
| frm_done | output | 1 | One-cycle verdict strobe |
| frm_class | output | 2 | Verdict code, valid with frm_done |

## Verification
The verdict (`frm_done`, `frm_class`) and the status bits change on the same clock edge that samples the final bit of the closing flag or the seventh one of an abort, and `irq` follows one edge later. A clear or an enable change takes effect in status or `irq` at the next edge. The bench drives every input on the falling edge. It samples the verdict and status at the very next falling edge after the last line bit, and `irq` one falling edge after that, so every check lands in the cycle the result is due. The bench builds each frame independently: it inserts stuffed zeros itself and computes the FCS with a bit-reversed register.

// File: rtl/hdlc_rx_err_pkg.sv
package hdlc_rx_err_pkg;

  typedef enum logic [1:0] {
    CLS_GOOD  = 2'd0,
    CLS_FCS   = 2'd1,
    CLS_ABORT = 2'd2,
    CLS_FMT   = 2'd3
  } frm_cls_e;

  localparam int NUM_ERR = 3;
  localparam int ST_FCS  = 0;
  localparam int ST_ABT  = 1;
  localparam int ST_FMT  = 2;

  // destuffed bits that a flag leaves behind before it is recognised
  localparam int FLAG_PUSH = 6;

  localparam logic [2:0] RUN_STUFF = 3'd5;
  localparam logic [2:0] RUN_FLAG  = 3'd6;
  localparam logic [2:0] RUN_SAT   = 3'd7;

  localparam int MIN_BITS_C16 = 32;
  localparam int MIN_BITS_C32 = 48;

  localparam logic [15:0] C16_POLY = 16'h1021;
  localparam logic [15:0] C16_GOOD = 16'h1D0F;
  localparam logic [31:0] C32_POLY = 32'h04C11DB7;
  localparam logic [31:0] C32_GOOD = 32'hC704DD7B;

  function automatic logic [15:0] c16_step(input logic [15:0] c, input logic b);
    c16_step = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? C16_POLY : 16'h0000);
  endfunction

  function automatic logic [31:0] c32_step(input logic [31:0] c, input logic b);
    c32_step = {c[30:0], 1'b0} ^ ((c[31] ^ b) ? C32_POLY : 32'h0);
  endfunction

endpackage

// File: rtl/hdlc_rx_destuff.sv
module hdlc_rx_destuff
  import hdlc_rx_err_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit_i,
  input  logic             rx_vld_i,
  output logic             flag_p_o,
  output logic             exit_vld_o,
  output logic             exit_bit_o,
  output logic             close_p_o,
  output logic             abort_p_o,
  output logic [CNT_W-1:0] frame_len_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] FP      = CNT_W'(FLAG_PUSH);
  localparam logic [CNT_W-1:0] FP_M1   = CNT_W'(FLAG_PUSH - 1);

  logic [2:0]           ones_q, ones_d;
  logic                 open_q;
  logic [CNT_W-1:0]     npush_q;
  logic [FLAG_PUSH-1:0] dly_q;
  logic                 flag_c, abort_run, push, push_open;

  always_comb begin
    ones_d    = ones_q;
    flag_c    = 1'b0;
    abort_run = 1'b0;
    push      = 1'b0;
    if (rx_vld_i) begin
      if (rx_bit_i) begin
        abort_run = (ones_q == RUN_FLAG);
        push      = (ones_q < RUN_STUFF);
        if (ones_q != RUN_SAT) ones_d = ones_q + 3'd1;
      end else begin
        flag_c = (ones_q == RUN_FLAG);
        push   = (ones_q < RUN_STUFF);
        ones_d = 3'd0;
      end
    end
  end

  assign push_open = push && open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q  <= 3'd0;
      open_q  <= 1'b0;
      npush_q <= '0;
      dly_q   <= '0;
    end else begin
      ones_q <= ones_d;
      if (flag_c) begin
        open_q  <= 1'b1;
        npush_q <= '0;
      end else if (abort_run) begin
        open_q <= 1'b0;
      end else if (push_open) begin
        dly_q <= {dly_q[FLAG_PUSH-2:0], rx_bit_i};
        if (npush_q != CNT_MAX) npush_q <= npush_q + 1'b1;
      end
    end
  end

  assign flag_p_o    = flag_c;
  assign exit_vld_o  = push_open && (npush_q >= FP);
  assign exit_bit_o  = dly_q[FLAG_PUSH-1];
  assign close_p_o   = flag_c && open_q && (npush_q > FP);
  assign abort_p_o   = abort_run && open_q && (npush_q > FP_M1);
  assign frame_len_o = npush_q - FP;

  // R4: after an abort no data leaves the delay line until a new flag
  a_r4_hunt_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p_o |=> !exit_vld_o);

  // R2: a frame never closes and aborts in the same cycle
  a_r2_close_or_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({close_p_o, abort_p_o}));

endmodule

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs
  import hdlc_rx_err_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic flag_p_i,
  input  logic exit_vld_i,
  input  logic exit_bit_i,
  output logic c16_ok_o,
  output logic c32_ok_o
);

  logic [15:0] c16_q;
  logic [31:0] c32_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c16_q <= '1;
      c32_q <= '1;
    end else if (flag_p_i) begin
      c16_q <= '1;
      c32_q <= '1;
    end else if (exit_vld_i) begin
      c16_q <= c16_step(c16_q, exit_bit_i);
      c32_q <= c32_step(c32_q, exit_bit_i);
    end
  end

  assign c16_ok_o = (c16_q == C16_GOOD);
  assign c32_ok_o = (c32_q == C32_GOOD);

endmodule

// File: rtl/hdlc_rx_classify.sv
module hdlc_rx_classify
  import hdlc_rx_err_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int CNT_W = LEN_W + 4
) (
  input  logic               close_p_i,
  input  logic               abort_p_i,
  input  logic [CNT_W-1:0]   frame_len_i,
  input  logic [LEN_W-1:0]   max_octets_i,
  input  logic               crc32_sel_i,
  input  logic               c16_ok_i,
  input  logic               c32_ok_i,
  output logic [NUM_ERR-1:0] err_ev_o,
  output frm_cls_e           cls_o
);

  logic [CNT_W-1:0] min_bits, max_bits;
  logic             len_bad, fcs_bad;

  assign min_bits = crc32_sel_i ? CNT_W'(MIN_BITS_C32) : CNT_W'(MIN_BITS_C16);
  assign max_bits = {1'b0, max_octets_i, 3'b000};

  assign len_bad = (frame_len_i[2:0] != 3'd0) ||
                   (frame_len_i < min_bits) ||
                   (frame_len_i > max_bits);
  assign fcs_bad = crc32_sel_i ? !c32_ok_i : !c16_ok_i;

  always_comb begin
    err_ev_o         = '0;
    err_ev_o[ST_ABT] = abort_p_i;
    err_ev_o[ST_FMT] = close_p_i && len_bad;
    err_ev_o[ST_FCS] = close_p_i && !len_bad && fcs_bad;
    if (abort_p_i)              cls_o = CLS_ABORT;
    else if (len_bad)           cls_o = CLS_FMT;
    else if (fcs_bad)           cls_o = CLS_FCS;
    else                        cls_o = CLS_GOOD;
  end

endmodule

// File: rtl/hdlc_rx_sticky.sv
module hdlc_rx_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] st_o,
  output logic         irq_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= set_i[i] | (bit_q & ~clr_i[i]);
    end
    assign st_o[i] = bit_q;

    // R10: a set bit holds unless its own clear arrives
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      bit_q && !clr_i[i] |=> bit_q);
    // R10: an event wins over a coincident clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> bit_q);
  end

  logic irq_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(st_o & en_i);
  end
  assign irq_o = irq_q;

  // R11: with every enable low the interrupt is low one cycle later
  a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o);

endmodule

// File: rtl/hdlc_rx_err_det.sv
module hdlc_rx_err_det
  import hdlc_rx_err_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_bit,
  input  logic                rx_vld,
  input  logic                crc32_sel,
  input  logic [LEN_W-1:0]    max_octets,
  input  logic [NUM_ERR-1:0]  int_en,
  input  logic [NUM_ERR-1:0]  stat_clr,
  output logic [NUM_ERR-1:0]  stat,
  output logic                irq,
  output logic                frm_done,
  output logic [1:0]          frm_class
);

  localparam int CNT_W = LEN_W + 4;

  logic               flag_p, exit_vld, exit_bit, close_p, abort_p;
  logic [CNT_W-1:0]   frame_len;
  logic               c16_ok, c32_ok;
  logic [NUM_ERR-1:0] err_ev;
  frm_cls_e           cls;

  hdlc_rx_destuff #(.CNT_W(CNT_W)) u_destuff (
    .clk(clk), .rst_n(rst_n), .rx_bit_i(rx_bit), .rx_vld_i(rx_vld),
    .flag_p_o(flag_p), .exit_vld_o(exit_vld), .exit_bit_o(exit_bit),
    .close_p_o(close_p), .abort_p_o(abort_p), .frame_len_o(frame_len)
  );

  hdlc_rx_fcs u_fcs (
    .clk(clk), .rst_n(rst_n), .flag_p_i(flag_p), .exit_vld_i(exit_vld),
    .exit_bit_i(exit_bit), .c16_ok_o(c16_ok), .c32_ok_o(c32_ok)
  );

  hdlc_rx_classify #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_classify (
    .close_p_i(close_p), .abort_p_i(abort_p), .frame_len_i(frame_len),
    .max_octets_i(max_octets), .crc32_sel_i(crc32_sel),
    .c16_ok_i(c16_ok), .c32_ok_i(c32_ok), .err_ev_o(err_ev), .cls_o(cls)
  );

  hdlc_rx_sticky #(.N(NUM_ERR)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(err_ev), .clr_i(stat_clr),
    .en_i(int_en), .st_o(stat), .irq_o(irq)
  );

  logic     done_q;
  frm_cls_e cls_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      cls_q  <= CLS_GOOD;
    end else begin
      done_q <= close_p || abort_p;
      if (close_p || abort_p) cls_q <= cls;
    end
  end
  assign frm_done  = done_q;
  assign frm_class = cls_q;

  // R8: at most one error class is raised per verdict
  a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(err_ev));

  // R9: every error event is accompanied by a verdict strobe
  a_r9_event_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_ev) |=> frm_done);

endmodule

// File: tb/hdlc_rx_err_det_bench.sv
module hdlc_rx_err_det_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 12;
  localparam int NV         = 14;

  // {c32, ndata[4:0], extra_bits[2:0], flip_fcs, class[1:0]}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 5'd4, 3'd0, 1'b0, 2'd0},
    {1'b1, 5'd5, 3'd0, 1'b0, 2'd0},
    {1'b0, 5'd4, 3'd0, 1'b1, 2'd1},
    {1'b1, 5'd3, 3'd0, 1'b1, 2'd1},
    {1'b0, 5'd1, 3'd0, 1'b0, 2'd3},
    {1'b0, 5'd2, 3'd0, 1'b0, 2'd0},
    {1'b1, 5'd1, 3'd0, 1'b0, 2'd3},
    {1'b1, 5'd2, 3'd0, 1'b0, 2'd0},
    {1'b0, 5'd9, 3'd0, 1'b0, 2'd3},
    {1'b0, 5'd8, 3'd0, 1'b0, 2'd0},
    {1'b1, 5'd7, 3'd0, 1'b0, 2'd3},
    {1'b1, 5'd6, 3'd0, 1'b0, 2'd0},
    {1'b0, 5'd4, 3'd3, 1'b0, 2'd3},
    {1'b0, 5'd1, 3'd0, 1'b1, 2'd3}
  };

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             rx_bit = 1'b0, rx_vld = 1'b0, crc32_sel = 1'b0;
  logic [LEN_W-1:0] max_octets = LEN_W'(10);
  logic [2:0]       int_en = 3'b000, stat_clr = 3'b000;
  logic [2:0]       stat;
  logic             irq, frm_done;
  logic [1:0]       frm_class;

  int checks = 0, fails = 0, done_cnt = 0, tb_ones = 0;
  bit gappy = 1'b0, finished = 1'b0;

  hdlc_rx_err_det #(.LEN_W(LEN_W)) u_hdlc_rx_err_det (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_vld(rx_vld),
    .crc32_sel(crc32_sel), .max_octets(max_octets), .int_en(int_en),
    .stat_clr(stat_clr), .stat(stat), .irq(irq), .frm_done(frm_done),
    .frm_class(frm_class)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n && frm_done) done_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic raw(input logic b);
    if (gappy) begin @(negedge clk); rx_vld = 1'b0; end
    @(negedge clk); rx_vld = 1'b1; rx_bit = b;
  endtask

  task automatic stuffed(input logic b);
    raw(b);
    if (b) begin
      tb_ones++;
      if (tb_ones == 5) begin raw(1'b0); tb_ones = 0; end
    end else tb_ones = 0;
  endtask

  task automatic flag(input logic [2:0] clr_last);
    for (int i = 0; i < 8; i++) begin
      raw((i == 0 || i == 7) ? 1'b0 : 1'b1);
      if (i == 7) stat_clr = clr_last;
    end
    tb_ones = 0;
  endtask

  // bit-reversed register form, output sent low bit first
  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic b, input logic w32);
    logic fb;
    logic [31:0] n;
    fb = c[0] ^ b;
    n  = c >> 1;
    if (fb) n = n ^ (w32 ? 32'hEDB88320 : 32'h00008408);
    return n;
  endfunction

  function automatic logic [7:0] pay(input int v, input int k);
    return (k == 1) ? 8'hFF : 8'((v * 53 + k * 29 + 7));
  endfunction

  task automatic frame(input logic w32, input int nd, input int xb, input logic flip,
                       input int v, input logic [2:0] clr_last);
    logic [31:0] c;
    logic [7:0]  by;
    int fw;
    c  = w32 ? 32'hFFFFFFFF : 32'h0000FFFF;
    fw = w32 ? 32 : 16;
    crc32_sel = w32;
    flag(3'b000);
    for (int k = 0; k < nd; k++) begin
      by = pay(v, k);
      for (int j = 0; j < 8; j++) begin
        stuffed(by[j]);
        c = ref_crc(c, by[j], w32);
      end
    end
    c = ~c;
    if (flip) c[3] = ~c[3];
    for (int j = 0; j < fw; j++) stuffed(c[j]);
    for (int j = 0; j < xb; j++) stuffed(1'b0);
    flag(clr_last);
    @(negedge clk); rx_vld = 1'b0; stat_clr = 3'b000;
  endtask

  function automatic logic [2:0] exp_stat(input logic [1:0] cls);
    case (cls)
      2'd1:    return 3'b001;
      2'd2:    return 3'b010;
      2'd3:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string vtag(input int v);
    if (v < 4)       return "R3";
    else if (v < 8)  return "R5";
    else if (v < 12) return "R6";
    else if (v == 12) return "R7";
    else             return "R8";
  endfunction

  task automatic clear_all();
    @(negedge clk); stat_clr = 3'b111;
    @(negedge clk); stat_clr = 3'b000;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int d0;
    logic [11:0] e;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 stat in reset", 32'(stat), 0);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stat after reset", 32'(stat), 0);
    chk("R1 done after reset", 32'(frm_done), 0);

    // table walk: R2 (0xFF payloads), R3, R5, R6, R7, R8, R9, R11
    int_en = 3'b111;
    for (int v = 0; v < NV; v++) begin
      e = VEC[v];
      gappy = ((v % 3) == 2);
      frame(e[11], int'(e[10:6]), int'(e[5:3]), e[2], v, 3'b000);
      chk($sformatf("R9 vec%0d done", v), 32'(frm_done), 1);
      chk($sformatf("%s vec%0d class", vtag(v), v), 32'(frm_class), 32'(e[1:0]));
      chk($sformatf("%s vec%0d stat", vtag(v), v), 32'(stat), 32'(exp_stat(e[1:0])));
      @(negedge clk);
      chk($sformatf("R11 vec%0d irq", v), 32'(irq), (e[1:0] != 2'd0) ? 1 : 0);
      clear_all();
    end
    gappy = 1'b0;

    // R2: flags back to back report nothing
    d0 = done_cnt;
    flag(3'b000); flag(3'b000); flag(3'b000);
    @(negedge clk); rx_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 empty frames no verdict", 32'(done_cnt), 32'(d0));
    chk("R2 empty frames no status", 32'(stat), 0);

    // R4: idle ones after a flag are not an abort
    flag(3'b000);
    for (int i = 0; i < 10; i++) raw(1'b1);
    @(negedge clk); rx_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 idle ones no verdict", 32'(done_cnt), 32'(d0));
    chk("R4 idle ones no status", 32'(stat), 0);

    // R4 / R8: a real abort
    flag(3'b000);
    for (int j = 0; j < 8; j++) stuffed(1'b0);
    for (int j = 0; j < 8; j++) stuffed(j inside {2, 3, 4, 5});
    for (int i = 0; i < 7; i++) raw(1'b1);
    @(negedge clk); rx_vld = 1'b0;
    chk("R4 abort done", 32'(frm_done), 1);
    chk("R4 abort class", 32'(frm_class), 2);
    chk("R8 abort only status", 32'(stat), 32'h2);
    clear_all();
    // R4: hunt until flag, then a good frame is accepted
    raw(1'b0); raw(1'b1); raw(1'b0); raw(1'b1);
    frame(1'b0, 4, 0, 1'b0, 3, 3'b000);
    chk("R4 recovery class", 32'(frm_class), 0);
    chk("R9 good frame no status", 32'(stat), 0);

    // R11: masked status still sets; interrupt follows enables
    int_en = 3'b000;
    frame(1'b0, 4, 0, 1'b1, 5, 3'b000);
    chk("R11 status set while masked", 32'(stat), 32'h1);
    @(negedge clk);
    chk("R11 irq low while masked", 32'(irq), 0);
    int_en = 3'b001;
    @(negedge clk);
    chk("R11 irq after enable", 32'(irq), 1);
    int_en = 3'b110;
    @(negedge clk);
    chk("R11 irq other classes only", 32'(irq), 0);

    // R10: set wins over a same-cycle clear
    frame(1'b0, 4, 0, 1'b1, 6, 3'b001);
    chk("R10 set wins", 32'(stat), 32'h1);
    stat_clr = 3'b110;
    @(negedge clk); stat_clr = 3'b000;
    repeat (3) @(negedge clk);
    chk("R10 other clear no effect", 32'(stat), 32'h1);
    stat_clr = 3'b001;
    @(negedge clk); stat_clr = 3'b000;
    chk("R10 clear", 32'(stat), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule